// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a NOR-style flash memory. Every bus write cycle gives it an address and a data word, and the command code is the low byte of that word. The decoder follows multi-cycle instruction sequences. Each sequence opens with a two-write unlock prefix and continues with a setup code. Some sequences then need payload writes, and erase needs a second unlock prefix and a confirm code. A write that does not fit the expected sequence drops the decoder back to array reads.

When a sequence completes, the decoder issues a one-cycle operation request to the program/erase engine. The request carries the captured address and data. After that the decoder waits for the engine's done pulse, and it ignores all writes meanwhile. The one exception is an erase, which can be suspended and resumed. A second output selects what the read data path returns: array data, one of the identification words of auto-select mode, or query data. Query mode has its own window for the security number.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, rd_mode is 0 (array), req_valid is low and rd_sel is 0.
- R2: The unlock prefix is command AAh at unlock address 555h, then command 55h at 2AAh. The command is wr_data[7:0]. Only wr_addr[10:0] is compared, so higher address bits and wr_data[15:8] do not matter.
- R3: Prefix + A0h + one write issues op 1 (program). The request carries that write's address and data in req_addr0/req_data0, and req_addr1/req_data1 are zero. req_valid is high for exactly the cycle after the clock edge that samples the completing write.
- R4: Prefix + 40h + two writes issues op 2 (double-word program). The first write goes to req_addr0/req_data0 and the second to req_addr1/req_data1.
- R5: Prefix + 80h + a second prefix + 30h issues op 3 (block erase). With 10h in place of 30h it issues op 4 (bank erase). The confirm write goes to req_addr0/req_data0.
- R6: Prefix + 60h + one write issues op 7 (protect), carrying that write.
- R7: Any write that breaks a sequence discards it without a request. The next write is judged as the first write of a new sequence.
- R8: F0h selects array mode, with or without the prefix. In auto-select or query mode, every write other than F0h is ignored.
- R9: 98h at address 055h sets rd_mode 2 (query). rd_sel is then 6 when rd_addr[7:0] is 80h to 83h, and 5 otherwise.
- R10: Prefix + 90h at 555h sets rd_mode 1 (auto-select). rd_sel is then 1 + rd_addr[1:0] if rd_addr[7:2] is zero, and 7 otherwise.
- R11: After a request, writes are ignored until eng_done. The decoder then returns to array mode and accepts a new sequence. eng_done is ignored when no operation is running.
- R12: While an erase runs, B0h issues op 5 (suspend). While suspended, only 30h is accepted, and it issues op 6 (resume) and returns to the running-erase state. eng_done is ignored while suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write cycle this clock |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data, command code in the low byte |
| eng_done | input | 1 | Engine finished the current operation |
| rd_addr | input | ADDR_W | Read address for the read selector |
| req_valid | output | 1 | One-cycle operation request |
| req_op | output | 3 | Operation code (1..7) |
| req_addr0 | output | ADDR_W | First captured address |
| req_data0 | output | DATA_W | First captured data |
| req_addr1 | output | ADDR_W | Second captured address (double-word only) |
| req_data1 | output | DATA_W | Second captured data (double-word only) |
| rd_mode | output | 2 | Read mode: 0 array, 1 auto-select, 2 query |
| rd_sel | output | 3 | Read data source selector |

## Verification
The bench aims at broken sequences at every depth: a wrong second unlock write, a wrong second erase prefix, and a wrong confirm code. A decoder that resynchronised badly would fire a stray request or swallow the next good prefix. It also sends unlock writes whose upper address and data bits are set. A decoder that compared too many bits would miss the unlock there. Further checks send full command sequences while the engine is busy, send done pulses while idle or suspended, and write non-reset codes in query and auto-select modes. These catch a request issued while busy, a resume lost to a stray done, and a mode left by the wrong write. The read selector is checked at the edges of the security window and with nonzero A7..A2.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int CMD_W  = 8;
    localparam int UNLK_W = 11;

    localparam logic [UNLK_W-1:0] KEY_ADDR_A = 11'h555;
    localparam logic [UNLK_W-1:0] KEY_ADDR_B = 11'h2AA;
    localparam logic [UNLK_W-1:0] QRY_ADDR   = 11'h055;

    localparam logic [CMD_W-1:0] C_KEY_A   = 8'hAA;
    localparam logic [CMD_W-1:0] C_KEY_B   = 8'h55;
    localparam logic [CMD_W-1:0] C_PROG    = 8'hA0;
    localparam logic [CMD_W-1:0] C_DPROG   = 8'h40;
    localparam logic [CMD_W-1:0] C_ERSETUP = 8'h80;
    localparam logic [CMD_W-1:0] C_PROT    = 8'h60;
    localparam logic [CMD_W-1:0] C_IDENT   = 8'h90;
    localparam logic [CMD_W-1:0] C_QUERY   = 8'h98;
    localparam logic [CMD_W-1:0] C_RESET   = 8'hF0;
    localparam logic [CMD_W-1:0] C_BLKCONF = 8'h30;
    localparam logic [CMD_W-1:0] C_BNKCONF = 8'h10;
    localparam logic [CMD_W-1:0] C_SUSP    = 8'hB0;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_PROG       = 3'd1,
        OP_DPROG      = 3'd2,
        OP_BLK_ERASE  = 3'd3,
        OP_BANK_ERASE = 3'd4,
        OP_SUSPEND    = 3'd5,
        OP_RESUME     = 3'd6,
        OP_PROTECT    = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        RM_ARRAY = 2'd0,
        RM_AUTO  = 2'd1,
        RM_QUERY = 2'd2
    } rmode_e;

    typedef enum logic [2:0] {
        RS_ARRAY  = 3'd0,
        RS_MANUF  = 3'd1,
        RS_DEVICE = 3'd2,
        RS_PROT   = 3'd3,
        RS_CFG    = 3'd4,
        RS_QUERY  = 3'd5,
        RS_SECURE = 3'd6,
        RS_BADSEL = 3'd7
    } rsel_e;

    typedef enum logic [3:0] {
        S_IDLE, S_KEY1, S_KEY2, S_PROG, S_DW1, S_DW2, S_PROT,
        S_EKEY0, S_EKEY1, S_ECONF, S_BUSY, S_ERASE, S_SUSP
    } seq_e;

    // Classification of one bus write
    typedef struct packed {
        logic             key_a;
        logic             key_b;
        logic             at_key;
        logic             at_qry;
        logic [CMD_W-1:0] code;
    } wr_cls_t;

    function automatic wr_cls_t classify(input logic [UNLK_W-1:0] a,
                                         input logic [CMD_W-1:0]  c);
        wr_cls_t r;
        r.at_key = (a == KEY_ADDR_A);
        r.at_qry = (a == QRY_ADDR);
        r.key_a  = r.at_key && (c == C_KEY_A);
        r.key_b  = (a == KEY_ADDR_B) && (c == C_KEY_B);
        r.code   = c;
        return r;
    endfunction

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
    import fcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [UNLK_W-1:0] addr_lo,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              eng_done,
    output logic              issue,
    output op_e               issue_op,
    output logic              hold_en,
    output rmode_e            mode
);
    seq_e    st_q, st_d;
    rmode_e  mode_d;
    wr_cls_t w;

    assign w = classify(addr_lo, cmd);

    always_comb begin
        st_d     = st_q;
        mode_d   = mode;
        issue    = 1'b0;
        issue_op = OP_NONE;
        hold_en  = 1'b0;
        unique case (st_q)
            S_IDLE: if (wr_en) begin
                if (mode != RM_ARRAY) begin
                    if (w.code == C_RESET) mode_d = RM_ARRAY;
                end else if (w.code == C_QUERY && w.at_qry) begin
                    mode_d = RM_QUERY;
                end else if (w.key_a) begin
                    st_d = S_KEY1;
                end
            end
            S_KEY1: if (wr_en) st_d = w.key_b ? S_KEY2 : S_IDLE;
            S_KEY2: if (wr_en) begin
                st_d = S_IDLE;
                case (w.code)
                    C_PROG:    st_d = S_PROG;
                    C_DPROG:   st_d = S_DW1;
                    C_PROT:    st_d = S_PROT;
                    C_ERSETUP: st_d = S_EKEY0;
                    C_IDENT:   if (w.at_key) mode_d = RM_AUTO;
                    default:   st_d = S_IDLE;
                endcase
            end
            S_PROG: if (wr_en) begin
                issue = 1'b1; issue_op = OP_PROG; st_d = S_BUSY;
            end
            S_PROT: if (wr_en) begin
                issue = 1'b1; issue_op = OP_PROTECT; st_d = S_BUSY;
            end
            S_DW1: if (wr_en) begin
                hold_en = 1'b1; st_d = S_DW2;
            end
            S_DW2: if (wr_en) begin
                issue = 1'b1; issue_op = OP_DPROG; st_d = S_BUSY;
            end
            S_EKEY0: if (wr_en) st_d = w.key_a ? S_EKEY1 : S_IDLE;
            S_EKEY1: if (wr_en) st_d = w.key_b ? S_ECONF : S_IDLE;
            S_ECONF: if (wr_en) begin
                st_d = S_IDLE;
                if (w.code == C_BLKCONF) begin
                    issue = 1'b1; issue_op = OP_BLK_ERASE; st_d = S_ERASE;
                end else if (w.code == C_BNKCONF) begin
                    issue = 1'b1; issue_op = OP_BANK_ERASE; st_d = S_ERASE;
                end
            end
            S_BUSY: if (eng_done) st_d = S_IDLE;
            S_ERASE: begin
                if (eng_done) begin
                    st_d = S_IDLE;
                end else if (wr_en && w.code == C_SUSP) begin
                    issue = 1'b1; issue_op = OP_SUSPEND; st_d = S_SUSP;
                end
            end
            S_SUSP: if (wr_en && w.code == C_BLKCONF) begin
                issue = 1'b1; issue_op = OP_RESUME; st_d = S_ERASE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= S_IDLE;
            mode <= RM_ARRAY;
        end else begin
            st_q <= st_d;
            mode <= mode_d;
        end
    end

endmodule

// File: rtl/fcd_req.sv
module fcd_req
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hold_en,
    input  logic              issue,
    input  op_e               issue_op,
    output logic              req_valid,
    output op_e               req_op,
    output logic [ADDR_W-1:0] req_addr0,
    output logic [DATA_W-1:0] req_data0,
    output logic [ADDR_W-1:0] req_addr1,
    output logic [DATA_W-1:0] req_data1
);
    logic [ADDR_W-1:0] held_a;
    logic [DATA_W-1:0] held_d;
    logic              two_word;

    assign two_word = (issue_op == OP_DPROG);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_a <= '0;
            held_d <= '0;
        end else if (hold_en) begin
            held_a <= wr_addr;
            held_d <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req_op    <= OP_NONE;
            req_addr0 <= '0;
            req_data0 <= '0;
            req_addr1 <= '0;
            req_data1 <= '0;
        end else begin
            req_valid <= issue;
            if (issue) begin
                req_op    <= issue_op;
                req_addr0 <= two_word ? held_a : wr_addr;
                req_data0 <= two_word ? held_d : wr_data;
                req_addr1 <= two_word ? wr_addr : '0;
                req_data1 <= two_word ? wr_data : '0;
            end
        end
    end

endmodule

// File: rtl/fcd_rsel.sv
module fcd_rsel
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  rmode_e            mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output rsel_e             sel
);
    localparam int LOW_W = 8;

    logic [LOW_W-1:0] lo;
    logic             unused_hi;

    assign lo        = rd_addr[LOW_W-1:0];
    assign unused_hi = ^rd_addr[ADDR_W-1:LOW_W];

    always_comb begin
        unique case (mode)
            RM_AUTO: begin
                if (lo[7:2] != '0) sel = RS_BADSEL;
                else case (lo[1:0])
                    2'd0:    sel = RS_MANUF;
                    2'd1:    sel = RS_DEVICE;
                    2'd2:    sel = RS_PROT;
                    default: sel = RS_CFG;
                endcase
            end
            RM_QUERY: sel = (lo[7:2] == 6'b100000) ? RS_SECURE : RS_QUERY;
            default:  sel = RS_ARRAY;
        endcase
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eng_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              req_valid,
    output logic [2:0]        req_op,
    output logic [ADDR_W-1:0] req_addr0,
    output logic [DATA_W-1:0] req_data0,
    output logic [ADDR_W-1:0] req_addr1,
    output logic [DATA_W-1:0] req_data1,
    output logic [1:0]        rd_mode,
    output logic [2:0]        rd_sel
);
    logic   issue;
    logic   hold_en;
    op_e    issue_op;
    op_e    op_q;
    rmode_e mode;
    rsel_e  sel;

    fcd_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr_lo  (wr_addr[UNLK_W-1:0]),
        .cmd      (wr_data[CMD_W-1:0]),
        .eng_done (eng_done),
        .issue    (issue),
        .issue_op (issue_op),
        .hold_en  (hold_en),
        .mode     (mode)
    );

    fcd_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk       (clk),
        .rst       (rst),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .hold_en   (hold_en),
        .issue     (issue),
        .issue_op  (issue_op),
        .req_valid (req_valid),
        .req_op    (op_q),
        .req_addr0 (req_addr0),
        .req_data0 (req_data0),
        .req_addr1 (req_addr1),
        .req_data1 (req_data1)
    );

    fcd_rsel #(.ADDR_W(ADDR_W)) u_rsel (
        .mode    (mode),
        .rd_addr (rd_addr),
        .sel     (sel)
    );

    assign req_op  = op_q;
    assign rd_mode = mode;
    assign rd_sel  = sel;

endmodule

// File: rtl/fcd_chk.sv
module fcd_chk #(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic [ADDR_W-1:0] req_addr0,
    input logic [DATA_W-1:0] req_data0,
    input logic [ADDR_W-1:0] req_addr1,
    input logic [1:0]        rd_mode,
    input logic [2:0]        rd_sel
);
    logic pv = 1'b0;
    always_ff @(posedge clk) pv <= 1'b1;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        pv && $past(rst) |-> (rd_mode == 2'd0) && !req_valid);

    // R3
    req_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        pv && req_valid |-> $past(wr_en));

    // R3
    prog_payload_chk: assert property (@(posedge clk) disable iff (rst)
        pv && req_valid && req_op == 3'd1 |->
            req_addr0 == $past(wr_addr) && req_data0 == $past(wr_data) && req_addr1 == '0);

    // R5
    erase_confirm_chk: assert property (@(posedge clk) disable iff (rst)
        pv && req_valid && req_op == 3'd3 |-> $past(wr_data[7:0]) == 8'h30);

    // R12
    suspend_code_chk: assert property (@(posedge clk) disable iff (rst)
        pv && req_valid && req_op == 3'd5 |-> $past(wr_data[7:0]) == 8'hB0);

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pv && !$past(rst) && !$past(wr_en) |-> $stable(rd_mode));

    // R9
    secure_window_chk: assert property (@(posedge clk) disable iff (rst)
        rd_mode == 2'd2 && rd_addr[7:2] == 6'b100000 |-> rd_sel == 3'd6);

    // R10
    ident_badsel_chk: assert property (@(posedge clk) disable iff (rst)
        rd_mode == 2'd1 && rd_addr[7:2] != 6'd0 |-> rd_sel == 3'd7);

endmodule

bind flash_cmd_decoder fcd_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr0 (req_addr0),
    .req_data0 (req_data0),
    .req_addr1 (req_addr1),
    .rd_mode   (rd_mode),
    .rd_sel    (rd_sel)
);

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
    localparam int AW = 21;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          eng_done = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          req_valid;
    logic [2:0]    req_op;
    logic [AW-1:0] req_addr0, req_addr1;
    logic [DW-1:0] req_data0, req_data1;
    logic [1:0]    rd_mode;
    logic [2:0]    rd_sel;

    always #2 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // behavioural reference state
    int            eng = 0;   // 0 idle, 1 busy, 2 erase running, 3 suspended
    int            mdl_mode = 0;
    bit            e_valid = 0;
    int            e_op = 0;
    logic [AW-1:0] e_a0, e_a1;
    logic [DW-1:0] e_d0, e_d1;
    logic [AW-1:0] qa[$];
    logic [DW-1:0] qw[$];

    function automatic bit key1(logic [AW-1:0] a, logic [DW-1:0] d);
        return a[10:0] == 11'h555 && d[7:0] == 8'hAA;
    endfunction
    function automatic bit key2(logic [AW-1:0] a, logic [DW-1:0] d);
        return a[10:0] == 11'h2AA && d[7:0] == 8'h55;
    endfunction

    function automatic int ref_sel(int m, logic [AW-1:0] ra);
        if (m == 1) return (ra[7:2] != 0) ? 7 : 1 + int'(ra[1:0]);
        if (m == 2) return (ra[7:0] >= 8'h80 && ra[7:0] <= 8'h83) ? 6 : 5;
        return 0;
    endfunction

    task automatic emit(int op, logic [AW-1:0] a0, logic [DW-1:0] d0,
                        logic [AW-1:0] a1, logic [DW-1:0] d1);
        e_valid = 1; e_op = op; e_a0 = a0; e_d0 = d0; e_a1 = a1; e_d1 = d1;
    endtask

    task automatic judge_queue();
        int n = qa.size();
        bit keep = 0;
        logic [7:0] c = (n >= 3) ? qw[2][7:0] : 8'h00;
        if (n == 1) begin
            if (qw[0][7:0] == 8'h98 && qa[0][10:0] == 11'h055) mdl_mode = 2;
            else keep = key1(qa[0], qw[0]);
        end else if (n == 2) keep = key2(qa[1], qw[1]);
        else if (n == 3) begin
            if (c == 8'h90 && qa[2][10:0] == 11'h555) mdl_mode = 1;
            else keep = (c == 8'hA0 || c == 8'h40 || c == 8'h60 || c == 8'h80);
        end else if (n == 4) begin
            if (c == 8'hA0) begin emit(1, qa[3], qw[3], '0, '0); eng = 1; end
            else if (c == 8'h60) begin emit(7, qa[3], qw[3], '0, '0); eng = 1; end
            else if (c == 8'h40) keep = 1;
            else keep = key1(qa[3], qw[3]);
        end else if (n == 5) begin
            if (c == 8'h40) begin emit(2, qa[3], qw[3], qa[4], qw[4]); eng = 1; end
            else keep = key2(qa[4], qw[4]);
        end else if (n == 6) begin
            if (qw[5][7:0] == 8'h30) begin emit(3, qa[5], qw[5], '0, '0); eng = 2; end
            else if (qw[5][7:0] == 8'h10) begin emit(4, qa[5], qw[5], '0, '0); eng = 2; end
        end
        if (!keep) begin qa.delete(); qw.delete(); end
    endtask

    always @(posedge clk) begin
        e_valid = 0;
        if (rst) begin
            eng = 0; mdl_mode = 0; qa.delete(); qw.delete();
        end else if (eng == 1) begin
            if (eng_done) eng = 0;
        end else if (eng == 2) begin
            if (eng_done) eng = 0;
            else if (wr_en && wr_data[7:0] == 8'hB0) begin
                emit(5, wr_addr, wr_data, '0, '0); eng = 3;
            end
        end else if (eng == 3) begin
            if (wr_en && wr_data[7:0] == 8'h30) begin
                emit(6, wr_addr, wr_data, '0, '0); eng = 2;
            end
        end else if (wr_en) begin
            if (mdl_mode != 0) begin
                if (wr_data[7:0] == 8'hF0) mdl_mode = 0;
            end else begin
                qa.push_back(wr_addr); qw.push_back(wr_data); judge_queue();
            end
        end
    end

    task automatic cmp(string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            cmp("req_valid", req_valid, e_valid);
            if (e_valid && req_valid) begin
                cmp("req_op", req_op, e_op);
                cmp("req_addr0", req_addr0, e_a0);
                cmp("req_data0", req_data0, e_d0);
                cmp("req_addr1", req_addr1, e_a1);
                cmp("req_data1", req_data1, e_d1);
            end
            cmp("rd_mode", rd_mode, mdl_mode);
            cmp("rd_sel", rd_sel, ref_sel(mdl_mode, rd_addr));
        end
    end

    task automatic drive(bit en, logic [AW-1:0] a, logic [DW-1:0] d, bit dn);
        @(negedge clk); #1;
        wr_en = en; wr_addr = a; wr_data = d; eng_done = dn;
    endtask
    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d); drive(1, a, d, 0); endtask
    task automatic idle(int n); for (int i = 0; i < n; i++) drive(0, '0, '0, 0); endtask
    task automatic done_pulse(); drive(0, '0, '0, 1); idle(2); endtask
    task automatic prefix(); wr(21'h555, 16'h00AA); wr(21'h2AA, 16'h0055); endtask
    task automatic set_rd(logic [AW-1:0] a); drive(0, '0, '0, 0); rd_addr = a; idle(1); endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle(3);
        drive(0, '0, '0, 0); rst = 1'b0;
        cur_req = "R1"; idle(3);

        cur_req = "R3"; prefix(); wr(21'h0ABCD, 16'h1234); idle(3); done_pulse();
        cur_req = "R2"; wr(21'h1F555, 16'h77AA); wr(21'h0AAAA, 16'h3355);
        wr(21'h00555, 16'h00A0); wr(21'h12000, 16'hCAFE); idle(2); done_pulse();
        cur_req = "R4"; prefix(); wr(21'h555, 16'h0040);
        wr(21'h00100, 16'h1111); wr(21'h00101, 16'h2222); idle(2); done_pulse();
        cur_req = "R5"; prefix(); wr(21'h555, 16'h0080); prefix(); wr(21'h08000, 16'h0030);
        idle(2); done_pulse();
        prefix(); wr(21'h555, 16'h0080); prefix(); wr(21'h555, 16'h0010); idle(2); done_pulse();
        cur_req = "R6"; prefix(); wr(21'h555, 16'h0060); wr(21'h04000, 16'h0001); idle(2); done_pulse();
        cur_req = "R12"; prefix(); wr(21'h555, 16'h0080); prefix(); wr(21'h10000, 16'h0030);
        idle(2); wr(21'h0, 16'h00B0); idle(1); wr(21'h555, 16'h00AA); wr(21'h0, 16'h0020);
        done_pulse(); wr(21'h0, 16'h0030); idle(2); done_pulse();
        cur_req = "R7"; wr(21'h555, 16'h00AA); wr(21'h2AA, 16'h0056); wr(21'h2AA, 16'h0055);
        wr(21'h555, 16'h00A0); wr(21'h00200, 16'h5555); idle(2);
        prefix(); wr(21'h555, 16'h0080); wr(21'h555, 16'h00AA); wr(21'h2AB, 16'h0055); idle(2);
        prefix(); wr(21'h555, 16'h0080); prefix(); wr(21'h555, 16'h0020); idle(2);
        prefix(); wr(21'h555, 16'h0033); prefix(); wr(21'h555, 16'h00A0); wr(21'h3, 16'h0003);
        idle(2); done_pulse();
        cur_req = "R11"; prefix(); wr(21'h555, 16'h00A0); wr(21'h00300, 16'h0F0F);
        prefix(); wr(21'h555, 16'h00A0); wr(21'h00301, 16'hF0F0); idle(2);
        done_pulse(); done_pulse(); prefix(); wr(21'h555, 16'h00A0); wr(21'h00302, 16'hAAAA);
        idle(2); done_pulse();
        cur_req = "R9"; wr(21'h555, 16'h0098); idle(1); set_rd(21'h80);
        wr(21'h055, 16'h0098); set_rd(21'h7F); set_rd(21'h80); set_rd(21'h83);
        set_rd(21'h84); set_rd(21'h1F081);
        cur_req = "R8"; prefix(); wr(21'h555, 16'h00A0); set_rd(21'h80);
        wr(21'h0, 16'h00F0); idle(2);
        cur_req = "R10"; prefix(); wr(21'h555, 16'h0090);
        for (int i = 0; i < 4; i++) set_rd(AW'(i));
        set_rd(21'h04); set_rd(21'h80); set_rd(21'h1FF02);
        cur_req = "R8"; prefix(); wr(21'h0, 16'h00F0); idle(1);
        prefix(); wr(21'h555, 16'h00F0); wr(21'h0, 16'h00F0); idle(2);
        cur_req = "R1"; drive(0, '0, '0, 0); rst = 1'b1; idle(2);
        drive(0, '0, '0, 0); rst = 1'b0; idle(3);
        finish_run();
    end

endmodule